// File: doc/BRIEF.md
# Dual-System Signed Adder/Subtractor

This block adds or subtracts two signed n-bit operands. A mode input chooses the number system: ones' complement or twos' complement. Both systems share one ripple datapath. For a subtraction the block complements the second operand in the chosen system and then adds. In twos' complement mode the "+1" enters as the carry into bit 0, and the carry out of the top bit is dropped. In ones' complement mode the bits of the second operand are only inverted, and any carry out of the top bit is fed back into bit 0 (end-around carry).

The arithmetic is combinational. Its results are captured in one register stage so that every output changes on a clock edge. A flag marks the ones' complement negative-zero pattern (all ones), which is passed through unchanged. Overflow is flagged for both systems.

Top module: `cpl_addsub`

## Requirements
- R1: Twos' complement add (ones_mode=0, sub_req=0): res_q equals (op_a + op_b) mod 2^W, and cout_q equals bit W of the unsigned sum.
- R2: Twos' complement subtract (ones_mode=0, sub_req=1): res_q and cout_q are the low W bits and bit W of op_a + ~op_b + 1.
- R3: In twos' complement mode, ovf_q is 1 exactly when the carry into bit W-1 differs from the carry out of bit W-1. For example, at W=4, 5+3 and -7-2 overflow, while 5+2 and -3-5 do not.
- R4: Ones' complement add (ones_mode=1, sub_req=0): the unsigned sum of the operands is formed. Its bit W is then added back into bit 0, and res_q is the low W bits of that result.
- R5: Ones' complement subtract (ones_mode=1, sub_req=1): op_b is bitwise inverted with no +1, then added as in R4.
- R6: In ones' complement mode, ovf_q is 1 exactly when op_a and the (possibly inverted) second operand have equal sign bits and the wrapped result's sign bit differs from them.
- R7: nzero_q is 1 exactly when ones_mode=1 and the result is all ones. That result is still output unchanged on res_q. In twos' complement mode nzero_q is always 0.
- R8: All outputs come from registers and reflect the inputs present at the previous rising clock edge. While rst_n is low (asynchronous, active low), all outputs are 0.
- R9: In ones' complement mode, cout_q reports the carry out of bit W-1 before the end-around wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| sub_req | input | 1 | 1 = op_a minus op_b, 0 = op_a plus op_b |
| ones_mode | input | 1 | 1 = ones' complement, 0 = twos' complement |
| res_q | output | W | Registered result |
| cout_q | output | 1 | Registered raw carry out of the top bit |
| ovf_q | output | 1 | Registered overflow flag |
| nzero_q | output | 1 | Registered ones' complement negative-zero flag |

## Verification
Every result, carry and flag is due exactly one rising edge after its operands are applied. The bench therefore drives inputs on a falling edge and reads the outputs on the next falling edge. One directed test changes the operands and reads the outputs just before the following rising edge, to confirm they still hold the previous result. Reset is asynchronous, so the reset test reads the outputs a moment after rst_n falls, with no clock edge in between.

// File: rtl/cpl_addsub_pkg.sv
package cpl_addsub_pkg;
    typedef enum logic {
        SYS_TWOS = 1'b0,
        SYS_ONES = 1'b1
    } num_sys_e;
endpackage

// File: rtl/cpl_operand_prep.sv
module cpl_operand_prep
    import cpl_addsub_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] b_in,
    input  logic         sub_req,
    input  num_sys_e     sys,
    output logic [W-1:0] b_eff,
    output logic         cin
);
    // Negation: ones' complement inverts; twos' complement inverts and adds one via cin.
    always_comb begin
        b_eff = sub_req ? ~b_in : b_in;
        cin   = sub_req && (sys == SYS_TWOS);
    end
endmodule

// File: rtl/cpl_ripple.sv
module cpl_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         c_sign,
    output logic         c_out
);
    logic [W:0] c;

    assign c[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_fa
        logic p, g;
        assign p        = a[i] ^ b[i];
        assign g        = a[i] & b[i];
        assign sum[i]   = p ^ c[i];
        assign c[i+1]   = g | (p & c[i]);
    end

    assign c_sign = c[W-1];
    assign c_out  = c[W];
endmodule

// File: rtl/cpl_wrap.sv
module cpl_wrap #(
    parameter int W = 4
) (
    input  logic [W-1:0] raw,
    input  logic         inc,
    output logic [W-1:0] wrapped
);
    // Incrementer chain; the raw value is at most 2^W-2 when inc=1, so no carry leaves.
    logic [W-1:0] c;

    assign c[0] = inc;

    for (genvar i = 0; i < W; i++) begin : g_ha
        assign wrapped[i] = raw[i] ^ c[i];
        if (i < W - 1) begin : g_nxt
            assign c[i+1] = raw[i] & c[i];
        end
    end
endmodule

// File: rtl/cpl_addsub.sv
module cpl_addsub
    import cpl_addsub_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         sub_req,
    input  logic         ones_mode,
    output logic [W-1:0] res_q,
    output logic         cout_q,
    output logic         ovf_q,
    output logic         nzero_q
);
    typedef struct packed {
        logic [W-1:0] res;
        logic         cout;
        logic         ovf;
        logic         nzero;
    } out_st_t;

    num_sys_e     sys;
    logic [W-1:0] b_eff;
    logic         cin;
    logic [W-1:0] raw_sum;
    logic         c_sign;
    logic         c_top;
    logic [W-1:0] wrapped;
    logic         wrap_en;

    out_st_t st_d, st_q;

    assign sys     = num_sys_e'(ones_mode);
    assign wrap_en = (sys == SYS_ONES) && c_top;

    cpl_operand_prep #(.W(W)) u_prep (
        .b_in    (op_b),
        .sub_req (sub_req),
        .sys     (sys),
        .b_eff   (b_eff),
        .cin     (cin)
    );

    cpl_ripple #(.W(W)) u_add (
        .a      (op_a),
        .b      (b_eff),
        .cin    (cin),
        .sum    (raw_sum),
        .c_sign (c_sign),
        .c_out  (c_top)
    );

    cpl_wrap #(.W(W)) u_wrap (
        .raw     (raw_sum),
        .inc     (wrap_en),
        .wrapped (wrapped)
    );

    always_comb begin
        st_d      = '0;
        st_d.cout = c_top;
        if (sys == SYS_ONES) begin
            st_d.res   = wrapped;
            st_d.ovf   = (op_a[W-1] == b_eff[W-1]) && (wrapped[W-1] != op_a[W-1]);
            st_d.nzero = &wrapped;
        end else begin
            st_d.res   = raw_sum;
            st_d.ovf   = c_sign ^ c_top;
            st_d.nzero = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_q   = st_q.res;
    assign cout_q  = st_q.cout;
    assign ovf_q   = st_q.ovf;
    assign nzero_q = st_q.nzero;
endmodule

// File: rtl/cpl_addsub_chk.sv
module cpl_addsub_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         sub_req,
    input logic         ones_mode,
    input logic [W-1:0] res_q,
    input logic         cout_q,
    input logic         ovf_q,
    input logic         nzero_q
);
    logic         armed_q;
    logic [W-1:0] a_p, b_p;
    logic         sub_p, ones_p;
    logic [W:0]   plain_sum;
    logic [W-1:0] be_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            a_p     <= '0;
            b_p     <= '0;
            sub_p   <= 1'b0;
            ones_p  <= 1'b0;
        end else begin
            armed_q <= 1'b1;
            a_p     <= op_a;
            b_p     <= op_b;
            sub_p   <= sub_req;
            ones_p  <= ones_mode;
        end
    end

    assign plain_sum = {1'b0, a_p} + {1'b0, b_p};
    assign be_p      = sub_p ? ~b_p : b_p;

    AST_TWOS_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !ones_p && !sub_p) |-> ({cout_q, res_q} == plain_sum)); // R1

    AST_TWOS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !ones_p) |->
            (ovf_q == ((a_p[W-1] == be_p[W-1]) && (res_q[W-1] != a_p[W-1])))); // R3

    AST_ONES_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ones_p && !sub_p) |->
            (res_q == (plain_sum[W-1:0] + {{(W-1){1'b0}}, plain_sum[W]}))); // R4

    AST_ONES_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ones_p && !sub_p) |-> (cout_q == plain_sum[W])); // R9

    AST_NZERO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        nzero_q |-> (ones_p && (&res_q))); // R7

    AST_NZERO_TWOS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !ones_p) |-> !nzero_q); // R7
endmodule

bind cpl_addsub cpl_addsub_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_a      (op_a),
    .op_b      (op_b),
    .sub_req   (sub_req),
    .ones_mode (ones_mode),
    .res_q     (res_q),
    .cout_q    (cout_q),
    .ovf_q     (ovf_q),
    .nzero_q   (nzero_q)
);

// File: tb/cpl_addsub_bench.sv
`timescale 1ns/1ps
module cpl_addsub_bench;
    localparam int W = 4;
    localparam int NV = 17;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic         sub_req = 1'b0, ones_mode = 1'b0;
    logic [W-1:0] res_q;
    logic         cout_q, ovf_q, nzero_q;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    cpl_addsub #(.W(W)) u_cpl_addsub (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .sub_req(sub_req), .ones_mode(ones_mode),
        .res_q(res_q), .cout_q(cout_q), .ovf_q(ovf_q), .nzero_q(nzero_q)
    );

    // {ones, sub, a, b, exp_res, exp_cout, exp_ovf, exp_nzero}
    localparam logic [16:0] VEC [NV] = '{
        {1'b0,1'b0,4'b0101,4'b0011,4'b1000,1'b0,1'b1,1'b0}, // R3 5+3 overflows
        {1'b0,1'b0,4'b0101,4'b0010,4'b0111,1'b0,1'b0,1'b0}, // R1 5+2
        {1'b0,1'b0,4'b1001,4'b1110,4'b0111,1'b1,1'b1,1'b0}, // R3 -7-2 overflows
        {1'b0,1'b0,4'b1101,4'b1011,4'b1000,1'b1,1'b0,1'b0}, // R1 -3-5 = -8
        {1'b0,1'b1,4'b0111,4'b0111,4'b0000,1'b1,1'b0,1'b0}, // R2 7-7
        {1'b0,1'b1,4'b0010,4'b0101,4'b1101,1'b0,1'b0,1'b0}, // R2 2-5
        {1'b0,1'b1,4'b0000,4'b1000,4'b1000,1'b0,1'b1,1'b0}, // R3 0-(-8)
        {1'b0,1'b0,4'b1111,4'b0001,4'b0000,1'b1,1'b0,1'b0}, // R1 carry dropped
        {1'b1,1'b0,4'b0100,4'b1101,4'b0010,1'b1,1'b0,1'b0}, // R4 end-around
        {1'b1,1'b0,4'b0011,4'b1100,4'b1111,1'b0,1'b0,1'b1}, // R7 negative zero
        {1'b1,1'b1,4'b0100,4'b0011,4'b0001,1'b1,1'b0,1'b0}, // R5 4-3
        {1'b1,1'b1,4'b0011,4'b0011,4'b1111,1'b0,1'b0,1'b1}, // R5 3-3 gives -0
        {1'b1,1'b0,4'b0101,4'b0011,4'b1000,1'b0,1'b1,1'b0}, // R6 5+3
        {1'b1,1'b0,4'b1010,4'b1100,4'b0111,1'b1,1'b1,1'b0}, // R6 -5-3
        {1'b1,1'b0,4'b1110,4'b1101,4'b1100,1'b1,1'b0,1'b0}, // R9 -1-2 raw carry
        {1'b1,1'b1,4'b0101,4'b1101,4'b0111,1'b0,1'b0,1'b0}, // R5 5-(-2)
        {1'b1,1'b0,4'b1111,4'b1111,4'b1111,1'b1,1'b0,1'b1}  // R7 -0 + -0
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R8 reset state
        #1;
        check("R8 reset", {9'd0, res_q, cout_q, ovf_q, nzero_q}, 16'd0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {ones_mode, sub_req, op_a, op_b} = VEC[i][16:7];
            @(negedge clk);
            check($sformatf("R1-vec %0d", i) == "" ? "" : $sformatf("vec %0d R1 R2 R3 R4 R5 R6 R7 R9", i),
                  {9'd0, res_q, cout_q, ovf_q, nzero_q}, {9'd0, VEC[i][6:0]});
        end

        // R8 latency: new operands must not show before the next rising edge
        @(negedge clk);
        ones_mode = 1'b0; sub_req = 1'b0; op_a = 4'b0001; op_b = 4'b0001;
        #1;
        check("R8 hold before edge", {9'd0, res_q, cout_q, ovf_q, nzero_q},
              {9'd0, VEC[NV-1][6:0]});
        @(negedge clk);
        check("R1 R8 after edge", {9'd0, res_q, cout_q, ovf_q, nzero_q},
              {9'd0, 4'b0010, 1'b0, 1'b0, 1'b0});

        // R7 negative zero absent in twos mode for an all-ones result
        @(negedge clk);
        ones_mode = 1'b0; sub_req = 1'b0; op_a = 4'b0011; op_b = 4'b1100;
        @(negedge clk);
        check("R7 twos all-ones", {9'd0, res_q, cout_q, ovf_q, nzero_q},
              {9'd0, 4'b1111, 1'b0, 1'b0, 1'b0});

        // R8 asynchronous reset mid-run clears nonzero outputs
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R8 async reset", {9'd0, res_q, cout_q, ovf_q, nzero_q}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        ones_mode = 1'b1; sub_req = 1'b1; op_a = 4'b1000; op_b = 4'b0111;
        @(negedge clk);
        // R6 ones: -7 - 7 -> 1000 + 1000 = 1 0000 -> 0001, overflow
        check("R6 R9 after reset", {9'd0, res_q, cout_q, ovf_q, nzero_q},
              {9'd0, 4'b0001, 1'b1, 1'b1, 1'b0});

        finish_run();
    end
endmodule